// File: doc/BRIEF.md
# CAN Transmit Mailbox Controller

This block holds the control and status byte for a single transmit mailbox of a CAN controller and tracks where the mailbox is in its life: empty, pending, or on the bus. Software sets the request and abort bits and clears the result flags through one byte-wide write port. Writing a 1 to a request or abort bit sets it. Writing a 1 to a status bit clears it. The byte can be read back at any time.

A CAN protocol engine sees the mailbox through a request line, a one-cycle grant, and a one-cycle done pulse that carries a two-bit result. A failed attempt is retried without help unless an abort is pending. An abort that arrives while a frame is on the bus waits for that attempt to end.

The block also gates writes to the payload storage so that they are accepted only while the mailbox is empty. It exports the empty state for use elsewhere, and it emits a one-cycle completion pulse for interrupt logic.

Top module: `can_txmb_ctrl`

## Requirements
- R1: After synchronous reset the byte reads 0x00, `mb_empty` is 1, and `eng_req` and `cmpl_pulse` are 0. A reset taken in the middle of a request returns the block to this state.
- R2: Bits 7 and 6 always read 0, and writing 1 to them has no effect.
- R3: Writing 1 to bit 0 (transmit request) while empty has the following effects one cycle later:
  - bit 0 reads 1;
  - bit 2 (completed) and bits 3 to 5 read 0;
  - `mb_empty` is 0;
  - `eng_req` is 1.
- R4: A grant while requesting moves the mailbox onto the bus, and `eng_req` falls. A done pulse with result 2'b00 (success) then has these effects:
  - bit 3 (transmit OK) and bit 2 read 1;
  - bit 4 and bit 5 read 0;
  - bits 0 and 1 read 0;
  - `mb_empty` is 1.
- R5: A done pulse with result 2'b01 (arbitration lost) or 2'b10 (error) while no abort is pending has these effects:
  - bit 4 or bit 5 is set to match the result;
  - bit 3 is cleared;
  - bit 0 stays 1 and bit 2 is unchanged;
  - the mailbox requests the bus again.
- R6: Writing 1 to bit 1 (abort) while empty is ignored, and bit 1 reads 0.
- R7: An abort written while pending sets bit 1 and drops `eng_req`. On the next cycle the mailbox is empty, bit 2 reads 1, and bits 0 and 1 read 0.
- R8: An abort written while on the bus waits for the attempt to end.
  - If the attempt succeeds, transmit OK is set and the abort is dropped.
  - If the attempt fails, the mailbox empties with bit 2 set and the failure bit shown.
- R9: Writing 1 to bit 2 clears bit 2 and bits 3 to 5. Writing 1 to bit 3, 4 or 5 alone clears only that bit.
- R10: When a software clear and a completion event fall in the same cycle, the completion wins and bit 2 reads 1.
- R11: `pay_wr_en` follows `pay_wr_req` only while the mailbox is empty, and is 0 otherwise.
- R12: `cmpl_pulse` is 1 for exactly the one cycle in which bit 2 first reads 1 after reading 0.
- R13: Writing 0 to bits 0 or 1 never clears them; software cannot withdraw a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Byte write strobe for the control/status byte |
| reg_wdata | input | REG_W | Write data: 1 sets bits 0-1, 1 clears bits 2-5 |
| reg_rdata | output | REG_W | Current control/status byte |
| eng_req | output | 1 | Mailbox asks the protocol engine for the bus |
| eng_grant | input | 1 | One-cycle grant from the protocol engine |
| eng_done | input | 1 | One-cycle end-of-attempt pulse |
| eng_result | input | 2 | Attempt result: 00 ok, 01 arbitration lost, 10/11 error |
| mb_empty | output | 1 | Mailbox is empty |
| pay_wr_req | input | 1 | Payload register write attempt |
| pay_wr_en | output | 1 | Gated payload write enable |
| cmpl_pulse | output | 1 | One-cycle pulse on a new completion |

## Verification
The bench builds the block with the default `REG_W` of 8. At that width the two always-zero top bits exist and are driven by the bench, so the write-ignore behaviour can be seen at the port. One vector walk runs the mailbox through every path:
- retries after arbitration loss and after an error;
- an abort while pending;
- aborts while on the bus that end in failure and in success;
- a software clear that collides with a completion.

Directed steps cover the payload gate and a reset taken during a request.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    typedef enum logic [1:0] {
        MB_EMPTY = 2'd0,
        MB_PEND  = 2'd1,
        MB_XMIT  = 2'd2
    } mb_state_e;

    localparam logic [1:0] TXR_OK  = 2'b00;
    localparam logic [1:0] TXR_ARB = 2'b01;

    localparam int CTL_BITS = 6;

    // Control/status fields, MSB first: bit 5 down to bit 0.
    typedef struct packed {
        logic terr;
        logic alst;
        logic txok;
        logic rqcp;
        logic abrq;
        logic txrq;
    } mb_ctl_t;

    typedef struct packed {
        logic attempt;
        logic finish;
        logic err;
        logic arb;
        logic ok;
    } mb_event_t;

    // Returns {err, arb, ok} for an engine result code.
    function automatic logic [2:0] res_flags(input logic [1:0] code);
        logic [2:0] f;
        f = 3'b000;
        if (code == TXR_OK)       f = 3'b001;
        else if (code == TXR_ARB) f = 3'b010;
        else                      f = 3'b100;
        return f;
    endfunction

endpackage

// File: rtl/can_txmb_fsm.sv
module can_txmb_fsm
    import can_txmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       txrq_set,
    input  logic       abort_pend,
    input  logic       eng_grant,
    input  logic       eng_done,
    input  logic [1:0] eng_result,
    output mb_state_e  state,
    output mb_event_t  ev,
    output logic       eng_req
);

    mb_state_e st_q, st_n;

    always_comb begin
        st_n = st_q;
        ev   = '0;
        case (st_q)
            MB_EMPTY: begin
                if (txrq_set) st_n = MB_PEND;
            end
            MB_PEND: begin
                if (abort_pend) begin
                    st_n      = MB_EMPTY;
                    ev.finish = 1'b1;
                end else if (eng_grant) begin
                    st_n = MB_XMIT;
                end
            end
            MB_XMIT: begin
                if (eng_done) begin
                    ev.attempt = 1'b1;
                    {ev.err, ev.arb, ev.ok} = res_flags(eng_result);
                    if (ev.ok || abort_pend) begin
                        st_n      = MB_EMPTY;
                        ev.finish = 1'b1;
                    end else begin
                        st_n = MB_PEND;
                    end
                end
            end
            default: st_n = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= MB_EMPTY;
        else     st_q <= st_n;
    end

    assign state   = st_q;
    assign eng_req = (st_q == MB_PEND) && !abort_pend;

endmodule

// File: rtl/can_txmb_regs.sv
module can_txmb_regs
    import can_txmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CTL_BITS-1:0] wdata,
    input  logic                is_empty,
    input  mb_event_t           ev,
    output mb_ctl_t             ctl,
    output logic                txrq_set,
    output logic                cmpl_pulse
);

    mb_ctl_t ctl_q, ctl_n;
    logic    abrq_set, sw_clr, pulse_q;

    assign txrq_set = wr_en && wdata[0] && is_empty;
    assign abrq_set = wr_en && wdata[1] && !is_empty;
    assign sw_clr   = wr_en && !ev.attempt && !ev.finish;

    always_comb begin
        ctl_n = ctl_q;
        // request bits: set by software, cleared only on completion
        if (ev.finish) begin
            ctl_n.txrq = 1'b0;
            ctl_n.abrq = 1'b0;
            ctl_n.rqcp = 1'b1;
        end else begin
            if (txrq_set) ctl_n.txrq = 1'b1;
            if (abrq_set) ctl_n.abrq = 1'b1;
        end
        // result bits
        if (ev.attempt) begin
            ctl_n.terr = ev.err;
            ctl_n.alst = ev.arb;
            ctl_n.txok = ev.ok;
        end else if (txrq_set) begin
            ctl_n.rqcp = 1'b0;
            ctl_n.txok = 1'b0;
            ctl_n.alst = 1'b0;
            ctl_n.terr = 1'b0;
        end else if (sw_clr) begin
            if (wdata[2]) begin
                ctl_n.rqcp = 1'b0;
                ctl_n.txok = 1'b0;
                ctl_n.alst = 1'b0;
                ctl_n.terr = 1'b0;
            end else begin
                if (wdata[3]) ctl_n.txok = 1'b0;
                if (wdata[4]) ctl_n.alst = 1'b0;
                if (wdata[5]) ctl_n.terr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_n;
            pulse_q <= ctl_n.rqcp && !ctl_q.rqcp;
        end
    end

    assign ctl        = ctl_q;
    assign cmpl_pulse = pulse_q;

endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
    import can_txmb_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             eng_req,
    input  logic             eng_grant,
    input  logic             eng_done,
    input  logic [1:0]       eng_result,
    output logic             mb_empty,
    input  logic             pay_wr_req,
    output logic             pay_wr_en,
    output logic             cmpl_pulse
);

    localparam int PAD_W = REG_W - CTL_BITS;

    mb_state_e state;
    mb_event_t ev;
    mb_ctl_t   ctl;
    logic      txrq_set;

    can_txmb_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .txrq_set   (txrq_set),
        .abort_pend (ctl.abrq),
        .eng_grant  (eng_grant),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .state      (state),
        .ev         (ev),
        .eng_req    (eng_req)
    );

    can_txmb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wdata      (reg_wdata[CTL_BITS-1:0]),
        .is_empty   (mb_empty),
        .ev         (ev),
        .ctl        (ctl),
        .txrq_set   (txrq_set),
        .cmpl_pulse (cmpl_pulse)
    );

    assign mb_empty  = (state == MB_EMPTY);
    assign pay_wr_en = pay_wr_req && mb_empty;

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_rdata = {{PAD_W{1'b0}}, ctl};
        end else begin : g_nopad
            assign reg_rdata = ctl;
        end
    endgenerate

endmodule

// File: rtl/can_txmb_ctrl_chk.sv
module can_txmb_ctrl_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] reg_rdata,
    input logic             eng_req,
    input logic             mb_empty,
    input logic             pay_wr_en,
    input logic             cmpl_pulse
);

    a_r2_top_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:6] == '0);

    a_r11_pay_gate: assert property (@(posedge clk) disable iff (rst)
        pay_wr_en |-> mb_empty);

    a_r12_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse == $rose(reg_rdata[2]));

    a_r3_req_needs_bit: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> (!mb_empty && reg_rdata[0]));

    a_r6_empty_no_req_bits: assert property (@(posedge clk) disable iff (rst)
        mb_empty |-> (reg_rdata[1:0] == 2'b00));

    a_r9_txok_needs_done: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[3] |-> reg_rdata[2]);

    a_r4_leave_empty_on_req: assert property (@(posedge clk) disable iff (rst)
        $fell(mb_empty) |-> reg_rdata[0]);

endmodule

bind can_txmb_ctrl can_txmb_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rdata  (reg_rdata),
    .eng_req    (eng_req),
    .mb_empty   (mb_empty),
    .pay_wr_en  (pay_wr_en),
    .cmpl_pulse (cmpl_pulse)
);

// File: tb/can_txmb_ctrl_bench.sv
module can_txmb_ctrl_bench;

    localparam int REG_W  = 8;
    localparam int NVEC   = 28;
    localparam int WD_CYC = 20000;

    logic             clk = 1'b0;
    logic             rst;
    logic             reg_wr_en;
    logic [REG_W-1:0] reg_wdata;
    logic [REG_W-1:0] reg_rdata;
    logic             eng_req;
    logic             eng_grant;
    logic             eng_done;
    logic [1:0]       eng_result;
    logic             mb_empty;
    logic             pay_wr_req;
    logic             pay_wr_en;
    logic             cmpl_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit fin    = 1'b0;

    always #4 clk = ~clk;

    can_txmb_ctrl #(.REG_W(REG_W)) u_can_txmb_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_req    (eng_req),
        .eng_grant  (eng_grant),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .mb_empty   (mb_empty),
        .pay_wr_req (pay_wr_req),
        .pay_wr_en  (pay_wr_en),
        .cmpl_pulse (cmpl_pulse)
    );

    // Row layout: [31:24] req tag, [23] wr, [22:15] wdata, [14] grant,
    // [13] done, [12:11] result, [10:3] exp rdata, [2] empty, [1] req, [0] pulse
    function automatic logic [31:0] v(input int rq, input bit wr,
                                      input logic [7:0] wd, input bit g,
                                      input bit d, input logic [1:0] rs,
                                      input logic [7:0] rd, input bit e,
                                      input bit r, input bit p);
        return {8'(rq), wr, wd, g, d, rs, rd, e, r, p};
    endfunction

    localparam logic [31:0] VEC [NVEC] = '{
        v(6,  1, 8'h02, 0, 0, 2'b00, 8'h00, 1, 0, 0), // R6 abort while empty
        v(2,  1, 8'hC0, 0, 0, 2'b00, 8'h00, 1, 0, 0), // R2 top bits ignored
        v(3,  1, 8'h01, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R3 request
        v(13, 1, 8'h00, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R13 zero write
        v(4,  0, 8'h00, 1, 0, 2'b00, 8'h01, 0, 0, 0), // R4 grant
        v(5,  0, 8'h00, 0, 1, 2'b01, 8'h11, 0, 1, 0), // R5 arb lost retry
        v(5,  0, 8'h00, 1, 0, 2'b00, 8'h11, 0, 0, 0), // R5 grant again
        v(5,  0, 8'h00, 0, 1, 2'b10, 8'h21, 0, 1, 0), // R5 error retry
        v(4,  0, 8'h00, 1, 0, 2'b00, 8'h21, 0, 0, 0), // R4 grant
        v(4,  0, 8'h00, 0, 1, 2'b00, 8'h0C, 1, 0, 1), // R4 success
        v(12, 0, 8'h00, 0, 0, 2'b00, 8'h0C, 1, 0, 0), // R12 pulse ends
        v(9,  1, 8'h08, 0, 0, 2'b00, 8'h04, 1, 0, 0), // R9 clear OK only
        v(9,  1, 8'h04, 0, 0, 2'b00, 8'h00, 1, 0, 0), // R9 clear completed
        v(3,  1, 8'h01, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R3 request
        v(7,  1, 8'h02, 0, 0, 2'b00, 8'h03, 0, 0, 0), // R7 abort pending
        v(7,  0, 8'h00, 0, 0, 2'b00, 8'h04, 1, 0, 1), // R7 aborted
        v(3,  1, 8'h01, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R3 request clears done
        v(4,  0, 8'h00, 1, 0, 2'b00, 8'h01, 0, 0, 0), // R4 grant
        v(8,  1, 8'h02, 0, 0, 2'b00, 8'h03, 0, 0, 0), // R8 abort on bus
        v(8,  0, 8'h00, 0, 0, 2'b00, 8'h03, 0, 0, 0), // R8 abort waits
        v(8,  0, 8'h00, 0, 1, 2'b01, 8'h14, 1, 0, 1), // R8 fail then empty
        v(3,  1, 8'h01, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R3 request
        v(4,  0, 8'h00, 1, 0, 2'b00, 8'h01, 0, 0, 0), // R4 grant
        v(8,  1, 8'h02, 0, 0, 2'b00, 8'h03, 0, 0, 0), // R8 abort on bus
        v(8,  0, 8'h00, 0, 1, 2'b00, 8'h0C, 1, 0, 1), // R8 success drops abort
        v(3,  1, 8'h01, 0, 0, 2'b00, 8'h01, 0, 1, 0), // R3 request
        v(4,  0, 8'h00, 1, 0, 2'b00, 8'h01, 0, 0, 0), // R4 grant
        v(10, 1, 8'h3C, 0, 1, 2'b00, 8'h0C, 1, 0, 1)  // R10 hw wins over clear
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        reg_wr_en  = 1'b0;
        reg_wdata  = '0;
        eng_grant  = 1'b0;
        eng_done   = 1'b0;
        eng_result = 2'b00;
        pay_wr_req = 1'b0;
    endtask

    task automatic check(input string tag, input logic [10:0] act,
                         input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] obs();
        return {reg_rdata, mb_empty, eng_req, cmpl_pulse};
    endfunction

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1", obs(), {8'h00, 1'b1, 1'b0, 1'b0});

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] row;
            string tag;
            row        = VEC[i];
            reg_wr_en  = row[23];
            reg_wdata  = row[22:15];
            eng_grant  = row[14];
            eng_done   = row[13];
            eng_result = row[12:11];
            tick();
            tag = $sformatf("R%0d row%0d", row[31:24], i);
            check(tag, obs(), row[10:0]);
            idle_inputs();
        end

        // R11 payload gate while empty and while pending
        tick();
        pay_wr_req = 1'b1;
        #1;
        check("R11 empty", {10'd0, pay_wr_en}, {10'd0, 1'b1});
        reg_wr_en = 1'b1;
        reg_wdata = 8'h01;
        tick();
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        #1;
        check("R11 pending", {10'd0, pay_wr_en}, {10'd0, 1'b0});
        pay_wr_req = 1'b0;

        // R1 reset during a pending request
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 midreset", obs(), {8'h00, 1'b1, 1'b0, 1'b0});

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule